// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out the four single-bit operations of a processor's integer datapath: test a bit, invert it, force it to zero, or force it to one. It takes the instruction's first word, the optional extension word, the value of a data register that can supply the bit number, the operand to work on and the current condition flags. One clock later it returns the modified operand, a write-back strobe and the updated flags.

The destination kind sets the operand width. A register destination is handled as a 32-bit long word. A memory destination is handled as a single byte held in the low eight bits of the operand. Only the zero flag changes: it reports the state of the chosen bit as it was before any modification. Effective-address decoding, register-file access and memory cycles belong to the surrounding datapath.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `wb_en`, `result` and `flags_out` are all zero.
- R2: A request accepted with `in_valid` high produces `out_valid` high on the following clock cycle. When `in_valid` is low, `out_valid` is low one cycle later.
- R3: Opcode bits 7:6 choose the operation on the selected bit: 00 leaves it unchanged (test), 01 inverts it, 10 clears it and 11 sets it.
- R4: When `dst_is_reg` is 1, the bit number is the low 5 bits of its source, so it is taken modulo 32, and all higher source bits are ignored. Bit 0 is the least significant bit.
- R5: When `dst_is_reg` is 0, the bit number is the low 3 bits of its source, so it is taken modulo 8. Result bits 31:8 equal operand bits 31:8.
- R6: Opcode bit 8 set to 1 takes the bit number from `bitreg_val` (dynamic form). Set to 0, it takes the bit number from `ext_word` (static form, opcode bits 11:8 = 1000).
- R7: `flags_out` bit 2 (Z) is 1 when the selected operand bit was 0 before modification, and 0 when it was 1.
- R8: The flag vector is ordered {X,N,Z,V,C} from bit 4 down to bit 0. X, N, V and C in `flags_out` equal `flags_in` of the same request.
- R9: `wb_en` is high together with `out_valid` for invert, clear and set, and low for test.
- R10: Every result bit other than the selected one equals the corresponding operand bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 16 | First instruction word |
| ext_word | input | 16 | Extension word holding the static bit number |
| bitreg_val | input | 32 | Data register value holding the dynamic bit number |
| dst_is_reg | input | 1 | 1: register destination (long), 0: memory byte |
| operand | input | 32 | Destination value before the operation |
| flags_in | input | 5 | Incoming {X,N,Z,V,C} |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operand after the operation |
| wb_en | output | 1 | Write the result back to the destination |
| flags_out | output | 5 | Updated {X,N,Z,V,C} |

## Verification
A wrong bit index, for example a modulus that is not reduced for byte destinations or a swapped source, shows on the cycle after the request: the wrong bit of `result` moves, or Z reports the wrong bit. A corrupted operation select shows as a result equal to the operand where a change was due, or as `wb_en` disagreeing with the opcode. Because each request is independent and passes through a single register, every fault appears at the ports on the very next cycle and affects no later request.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    BOP_TEST = 2'b00,
    BOP_FLIP = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_SET  = 2'b11
  } bop_e;

  localparam int FLG_W = 5;
  localparam int FLG_X = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;

  localparam int OPSEL_LSB = 6;
  localparam int DYN_BIT   = 8;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int OPC_W = 16
) (
  input  logic [OPC_W-1:0] opcode,
  output bop_e             op,
  output logic             dyn
);

  always_comb begin
    op  = bop_e'(opcode[OPSEL_LSB +: 2]);
    dyn = opcode[DYN_BIT];
  end

endmodule

// File: rtl/bitop_index.sv
module bitop_index #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int EXT_W  = 16,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int BIDX_W = $clog2(BYTE_W)
) (
  input  logic              dyn,
  input  logic              dst_reg,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [DATA_W-1:0] bitreg,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] src_low;

  always_comb begin
    src_low = dyn ? bitreg[IDX_W-1:0] : ext_word[IDX_W-1:0];
    if (dst_reg)
      idx = src_low;
    else
      idx = {{(IDX_W-BIDX_W){1'b0}}, src_low[BIDX_W-1:0]};
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  bop_e              op,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] result,
  output logic              was_zero,
  output logic              write
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic hit;
    always_comb begin
      hit = (idx == IDX_W'(i));
      if (!hit)
        result[i] = operand[i];
      else begin
        unique case (op)
          BOP_TEST: result[i] = operand[i];
          BOP_FLIP: result[i] = ~operand[i];
          BOP_CLR:  result[i] = 1'b0;
          BOP_SET:  result[i] = 1'b1;
          default:  result[i] = operand[i];
        endcase
      end
    end
  end

  always_comb begin
    was_zero = ~operand[idx];
    write    = (op != BOP_TEST);
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int OPC_W  = 16,
  parameter int EXT_W  = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [DATA_W-1:0] bitreg_val,
  input  logic              dst_is_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLG_W-1:0]  flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wb_en,
  output logic [FLG_W-1:0]  flags_out
);

  bop_e              op;
  logic              dyn;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] res_c;
  logic              zero_c;
  logic              write_c;

  bitop_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode (opcode),
    .op     (op),
    .dyn    (dyn)
  );

  bitop_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .EXT_W(EXT_W)) u_idx (
    .dyn      (dyn),
    .dst_reg  (dst_is_reg),
    .ext_word (ext_word),
    .bitreg   (bitreg_val),
    .idx      (idx)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op),
    .operand  (operand),
    .idx      (idx),
    .result   (res_c),
    .was_zero (zero_c),
    .write    (write_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & write_c;
      if (in_valid) begin
        result           <= res_c;
        flags_out        <= flags_in;
        flags_out[FLG_Z] <= zero_c;
      end
    end
  end

  // R1: outputs quiet on the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !wb_en && result == '0 && flags_out == '0));

  // R2: one-cycle latency
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8: untouched flags follow the request
  p_flags_keep_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[FLG_X] == $past(flags_in[FLG_X]) &&
                   flags_out[FLG_N] == $past(flags_in[FLG_N]) &&
                   flags_out[FLG_V] == $past(flags_in[FLG_V]) &&
                   flags_out[FLG_C] == $past(flags_in[FLG_C])));

  // R9: write-back only for modifying operations
  p_test_nowb_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (wb_en == ($past(opcode[OPSEL_LSB +: 2]) != 2'b00)));

  // R10: at most one bit differs from the operand
  p_one_bit_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(result ^ $past(operand)) <= 1));

  // R5: byte destination leaves the upper bits alone
  p_mem_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(dst_is_reg)) |->
      (result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W])));

endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] opcode;
  logic [15:0] ext_word;
  logic [31:0] bitreg_val;
  logic        dst_is_reg;
  logic [31:0] operand;
  logic [4:0]  flags_in;
  logic        out_valid;
  logic [31:0] result;
  logic        wb_en;
  logic [4:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bitop_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .ext_word(ext_word), .bitreg_val(bitreg_val), .dst_is_reg(dst_is_reg),
    .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .wb_en(wb_en), .flags_out(flags_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic [15:0] opc, input logic [15:0] ext,
                                 input logic [31:0] breg, input logic reg_dst);
    logic [31:0] src;
    src = opc[8] ? breg : {16'h0, ext};
    return reg_dst ? int'(src % 32) : int'(src % 8);
  endfunction

  function automatic logic [31:0] exp_res(input logic [1:0] sel, input logic [31:0] opd, input int k);
    logic [31:0] r;
    r = opd;
    case (sel)
      2'b01: r[k] = ~opd[k];
      2'b10: r[k] = 1'b0;
      2'b11: r[k] = 1'b1;
      default: r = opd;
    endcase
    return r;
  endfunction

  // drive at negedge, outputs checked at the next negedge
  task automatic run(input logic [1:0] sel, input logic dynf, input logic [15:0] ext,
                     input logic [31:0] breg, input logic reg_dst, input logic [31:0] opd,
                     input logic [4:0] fl, input string tag);
    int k;
    logic [31:0] er;
    logic [4:0]  ef;
    opcode     = {4'b0000, dynf ? 3'($urandom) : 3'b100, dynf, sel, 6'($urandom)};
    ext_word   = ext;
    bitreg_val = breg;
    dst_is_reg = reg_dst;
    operand    = opd;
    flags_in   = fl;
    in_valid   = 1'b1;
    k  = exp_idx(opcode, ext, breg, reg_dst);
    er = exp_res(sel, opd, k);
    ef = fl;
    ef[2] = ~opd[k];
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " R3 R10 result"}, result, er);
    check({tag, " R7 R8 flags"}, {27'b0, flags_out}, {27'b0, ef});
    check({tag, " R9 wb"}, {31'b0, wb_en}, {31'b0, sel != 2'b00});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; in_valid = 1'b0; opcode = '0; ext_word = '0; bitreg_val = '0;
    dst_is_reg = 1'b0; operand = '0; flags_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    check("R1 reset flags", {27'b0, flags_out}, 32'd0);
    check("R1 reset wb", {31'b0, wb_en}, 32'd0);
    in_valid = 1'b1;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // directed corners
    run(2'b11, 1'b0, 16'hFF1F, 32'h0, 1'b1, 32'h0000_0000, 5'b10101, "R4 set bit31 modulo32");
    check("R4 bit31 only", result, 32'h8000_0000);
    run(2'b10, 1'b1, 16'h0, 32'hFFFF_FFE0, 1'b1, 32'hFFFF_FFFF, 5'b01010, "R4 clr bit0 high ignored");
    check("R4 bit0 cleared", result, 32'hFFFF_FFFE);
    run(2'b01, 1'b0, 16'h000F, 32'h0, 1'b0, 32'hABCD_EF00, 5'b11111, "R5 flip mem modulo8");
    check("R5 bit7 flipped upper kept", result, 32'hABCD_EF80);
    run(2'b11, 1'b1, 16'h0003, 32'h0000_0045, 1'b1, 32'h0, 5'b0, "R6 dynamic source");
    check("R6 bit5 from register", result, 32'h0000_0020);
    run(2'b11, 1'b0, 16'h0003, 32'h0000_0045, 1'b1, 32'h0, 5'b0, "R6 static source");
    check("R6 bit3 from ext word", result, 32'h0000_0008);
    run(2'b00, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0000_0010, 5'b00100, "R7 test bit set");
    check("R7 Z clear on one", {31'b0, flags_out[2]}, 32'd0);
    run(2'b00, 1'b0, 16'h0004, 32'h0, 1'b1, 32'hFFFF_FFEF, 5'b11011, "R7 test bit zero");
    check("R7 Z set on zero", {31'b0, flags_out[2]}, 32'd1);
    check("R9 test unchanged", result, 32'hFFFF_FFEF);

    // random mix
    for (int i = 0; i < 400; i++) begin
      run(2'($urandom), 1'($urandom), 16'($urandom), $urandom, 1'($urandom),
          $urandom, 5'($urandom), "random");
    end

    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle valid low", {31'b0, out_valid}, 32'd0);
    check("R9 idle wb low", {31'b0, wb_en}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule